// File: doc/BRIEF.md
# Equivalent-Time Reflectometer Sweep Sequencer

This block runs the timing and data collection for a reflectometer that rebuilds a fast response waveform from many slow acquisitions. Each repetition period begins with a one-cycle stimulus pulse. A sampling strobe follows at a programmed delay. The delay has two parts. The coarse part is a whole number of clock cycles, counted inside the block. The fine part is a 5-bit code in 1/32-cycle steps, which an external delay element applies to the strobe. The converter returns one result per strobe, and the block adds that result into the accumulator of the channel being sampled.

The two traces of the differential pair are sampled in alternate repetitions, and each trace has its own accumulator. Once a delay point has collected its set number of results on both traces, the block sends two records on a valid/ready stream. Each record holds the point index, the channel and the sum. The delay then grows by one fine step and the next point starts. A start pulse launches a sweep from the programmed start delay. A done flag marks the acceptance of the last record. Configuration writes are taken only between sweeps.

Top module: `ets_sweep_seq`

## Requirements
- R1: While a sweep is acquiring, `stim` is high for one cycle at the start of each repetition, and successive repetitions of one point begin exactly `cfg_period` cycles apart. `strobe` is high for one cycle, exactly `coarse` cycles after `stim` in the same repetition (the same cycle when `coarse` is 0).
- R2: The delay of point p is `cfg_start_dly + p`, counted in 1/32-cycle units. `coarse` is that delay shifted right by 5, and `fine_code` is its low 5 bits. `fine_code` stays constant for every strobe of a point and carries into `coarse` when it wraps from 31 to 0.
- R3: The sweep is sequential. Each point takes exactly 2×`cfg_ovs` repetitions. Even-numbered repetitions (0, 2, …) sample channel 0 and odd-numbered ones sample channel 1. The delay advances by one fine step only after both records of the point have been accepted.
- R4: Each channel accumulator sums the `cfg_ovs` results of its channel for the current point and is cleared before the next point begins. It is SMP_W+OVS_W bits wide (21 by default), so 384 full-scale 12-bit results do not overflow.
- R5: Each point yields two records: first channel 0 (`out_chan`=0), then channel 1 (`out_chan`=1), each carrying the point index and the sum. While `out_valid` is high and `out_ready` is low, the record holds steady and no stimulus is issued.
- R6: A `start` pulse while idle clears all counters and begins a sweep. A `start` pulse while `busy` is high has no effect. `done` rises when the last point's channel-1 record is accepted, at which point `busy` falls. `done` stays high until the next accepted start.
- R7: A `cfg_wr` while `busy` is high is ignored. A `cfg_wr` while idle takes effect for the following sweeps.
- R8: After reset, `stim`, `strobe`, `out_valid`, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sweep (honoured only while idle) |
| cfg_wr | input | 1 | Load the configuration inputs (honoured only while idle) |
| cfg_start_dly | input | PER_W+5 | First delay point, in 1/32-cycle units |
| cfg_points | input | PTS_W | Number of delay points, at least 1 |
| cfg_ovs | input | OVS_W | Results per channel per point, at least 1 |
| cfg_period | input | PER_W | Repetition period in cycles; must exceed coarse delay plus converter latency |
| adc_valid | input | 1 | Converter result present |
| adc_data | input | SMP_W | Converter result |
| stim | output | 1 | Stimulus pulse |
| strobe | output | 1 | Sampling strobe, coarse-timed |
| fine_code | output | 5 | Sub-cycle delay code for the external delay element |
| out_valid | output | 1 | Record present |
| out_ready | input | 1 | Record accepted |
| out_point | output | PTS_W | Point index of the record |
| out_chan | output | 1 | Channel of the record |
| out_sum | output | SMP_W+OVS_W | Accumulated sum |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Last sweep completed |

## Verification
The accepted start edge makes `stim` appear in the cycle that follows. `strobe` is then due exactly `coarse` cycles later, and the bench measures that distance cycle by cycle from the last stimulus it saw. The converter model returns each result two cycles after its strobe. The expected per-channel sums are therefore fixed by the strobe order, and the bench computes them from the repetition index. All sampling happens on the falling edge. That places every registered change at the preceding rising edge, so records, the stall hold and the done flag are checked in the cycle where they must first appear.

// File: rtl/ets_pkg.sv
package ets_pkg;
    localparam int unsigned FINE_W = 5;
    localparam int unsigned NUM_CH = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_OUT0 = 2'd2,
        ST_OUT1 = 2'd3
    } seq_state_t;
endpackage

// File: rtl/ets_rep_timer.sv
module ets_rep_timer #(
    parameter int unsigned PER_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PER_W-1:0] period,
    input  logic [PER_W-1:0] coarse,
    output logic             stim,
    output logic             strobe,
    output logic             rep_end
);
    logic [PER_W-1:0] cnt;
    logic [PER_W-1:0] last_cnt;

    assign last_cnt = period - 1'b1;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == last_cnt) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign stim    = run && (cnt == '0);
    assign strobe  = run && (cnt == coarse);
    assign rep_end = run && (cnt == last_cnt);

    // R1: a repetition that ends while acquisition goes on is followed by a new stimulus
    assert_next_stim_R1: assert property (@(posedge clk) disable iff (rst)
        rep_end && run |=> stim || !run);
endmodule

// File: rtl/ets_accum.sv
module ets_accum #(
    parameter int unsigned SMP_W = 12,
    parameter int unsigned ACC_W = 21
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                clr,
    input  logic                                add,
    input  logic                                ch,
    input  logic [SMP_W-1:0]                    data,
    output logic [ets_pkg::NUM_CH-1:0][ACC_W-1:0] sums
);
    for (genvar g = 0; g < ets_pkg::NUM_CH; g++) begin : g_ch
        logic hit;
        assign hit = add && (ch == g[0]);

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                sums[g] <= '0;
            end else if (hit) begin
                sums[g] <= sums[g] + ACC_W'(data);
            end
        end

        // R4: an addition never wraps the accumulator
        assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
            hit && !clr |=> sums[g] >= $past(sums[g]));
    end
endmodule

// File: rtl/ets_sweep_ctrl.sv
module ets_sweep_ctrl
    import ets_pkg::*;
#(
    parameter int unsigned PER_W = 12,
    parameter int unsigned PTS_W = 11,
    parameter int unsigned OVS_W = 9,
    localparam int unsigned DLY_W = PER_W + FINE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             cfg_wr,
    input  logic [DLY_W-1:0] cfg_start_dly,
    input  logic [PTS_W-1:0] cfg_points,
    input  logic [OVS_W-1:0] cfg_ovs,
    input  logic [PER_W-1:0] cfg_period,
    input  logic             rep_end,
    input  logic             out_ready,
    output logic             run,
    output logic             chan_sel,
    output logic             acc_clr,
    output logic [DLY_W-1:0] delay,
    output logic [PER_W-1:0] period,
    output logic             out_valid,
    output logic             out_chan,
    output logic [PTS_W-1:0] out_point,
    output logic             busy,
    output logic             done
);
    seq_state_t       state;
    logic [DLY_W-1:0] start_q;
    logic [PTS_W-1:0] points_q;
    logic [OVS_W-1:0] ovs_q;
    logic [OVS_W:0]   rep;
    logic [OVS_W:0]   rep_top;
    logic             rep_last;
    logic             point_last;

    assign rep_top    = {ovs_q, 1'b0} - 1'b1;
    assign rep_last   = (rep == rep_top);
    assign point_last = (out_point == points_q - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            start_q   <= '0;
            points_q  <= '0;
            ovs_q     <= '0;
            period    <= '0;
            rep       <= '0;
            out_point <= '0;
            delay     <= '0;
            done      <= 1'b0;
        end else begin
            if (state == ST_IDLE && cfg_wr) begin
                start_q  <= cfg_start_dly;
                points_q <= cfg_points;
                ovs_q    <= cfg_ovs;
                period   <= cfg_period;
            end
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state     <= ST_RUN;
                        rep       <= '0;
                        out_point <= '0;
                        delay     <= start_q;
                        done      <= 1'b0;
                    end
                end
                ST_RUN: begin
                    if (rep_end) begin
                        if (rep_last) begin
                            state <= ST_OUT0;
                            rep   <= '0;
                        end else begin
                            rep <= rep + 1'b1;
                        end
                    end
                end
                ST_OUT0: begin
                    if (out_ready) state <= ST_OUT1;
                end
                ST_OUT1: begin
                    if (out_ready) begin
                        if (point_last) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            state     <= ST_RUN;
                            out_point <= out_point + 1'b1;
                            delay     <= delay + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign run       = (state == ST_RUN);
    assign chan_sel  = rep[0];
    assign busy      = (state != ST_IDLE);
    assign out_valid = (state == ST_OUT0) || (state == ST_OUT1);
    assign out_chan  = (state == ST_OUT1);
    assign acc_clr   = ((state == ST_IDLE) && start) ||
                       ((state == ST_OUT1) && out_ready && !point_last);

    // R5: a refused record is held unchanged
    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_chan) && $stable(out_point));
    // R6: done is only reported once the sequencer is idle
    assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    // R7: the configuration stays frozen while a sweep runs
    assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(start_q) && $stable(points_q) && $stable(ovs_q) && $stable(period));
    // R2: the delay only moves at a point boundary
    assert_delay_step_R2: assert property (@(posedge clk) disable iff (rst)
        run && $past(run) |-> $stable(delay));
endmodule

// File: rtl/ets_sweep_seq.sv
module ets_sweep_seq
    import ets_pkg::*;
#(
    parameter int unsigned PER_W = 12,
    parameter int unsigned PTS_W = 11,
    parameter int unsigned OVS_W = 9,
    parameter int unsigned SMP_W = 12,
    localparam int unsigned DLY_W = PER_W + FINE_W,
    localparam int unsigned ACC_W = SMP_W + OVS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              cfg_wr,
    input  logic [DLY_W-1:0]  cfg_start_dly,
    input  logic [PTS_W-1:0]  cfg_points,
    input  logic [OVS_W-1:0]  cfg_ovs,
    input  logic [PER_W-1:0]  cfg_period,
    input  logic              adc_valid,
    input  logic [SMP_W-1:0]  adc_data,
    output logic              stim,
    output logic              strobe,
    output logic [FINE_W-1:0] fine_code,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [PTS_W-1:0]  out_point,
    output logic              out_chan,
    output logic [ACC_W-1:0]  out_sum,
    output logic              busy,
    output logic              done
);
    logic                           run;
    logic                           chan_sel;
    logic                           acc_clr;
    logic                           rep_end;
    logic [DLY_W-1:0]               delay;
    logic [PER_W-1:0]               period;
    logic [NUM_CH-1:0][ACC_W-1:0]   sums;

    ets_sweep_ctrl #(.PER_W(PER_W), .PTS_W(PTS_W), .OVS_W(OVS_W)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .cfg_wr(cfg_wr),
        .cfg_start_dly(cfg_start_dly), .cfg_points(cfg_points),
        .cfg_ovs(cfg_ovs), .cfg_period(cfg_period),
        .rep_end(rep_end), .out_ready(out_ready),
        .run(run), .chan_sel(chan_sel), .acc_clr(acc_clr),
        .delay(delay), .period(period),
        .out_valid(out_valid), .out_chan(out_chan), .out_point(out_point),
        .busy(busy), .done(done)
    );

    ets_rep_timer #(.PER_W(PER_W)) u_timer (
        .clk(clk), .rst(rst), .run(run), .period(period),
        .coarse(delay[DLY_W-1:FINE_W]),
        .stim(stim), .strobe(strobe), .rep_end(rep_end)
    );

    ets_accum #(.SMP_W(SMP_W), .ACC_W(ACC_W)) u_accum (
        .clk(clk), .rst(rst), .clr(acc_clr),
        .add(run && adc_valid), .ch(chan_sel), .data(adc_data),
        .sums(sums)
    );

    assign fine_code = delay[FINE_W-1:0];
    assign out_sum   = sums[out_chan];

    // R5: no stimulus while a record waits
    assert_quiet_output_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !stim && !strobe);
    // R2: the fine code holds between the stimulus and the strobe of a repetition
    assert_fine_steady_R2: assert property (@(posedge clk) disable iff (rst)
        strobe && !stim |-> $stable(fine_code));
endmodule

// File: tb/ets_sweep_seq_tb.sv
module ets_sweep_seq_tb;
    localparam int PER_W = 12, PTS_W = 11, OVS_W = 9, SMP_W = 12;
    localparam int DLY_W = PER_W + 5, ACC_W = SMP_W + OVS_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, cfg_wr = 1'b0;
    logic [DLY_W-1:0] cfg_start_dly = '0;
    logic [PTS_W-1:0] cfg_points = '0;
    logic [OVS_W-1:0] cfg_ovs = '0;
    logic [PER_W-1:0] cfg_period = '0;
    logic adc_valid;
    logic [SMP_W-1:0] adc_data;
    logic stim, strobe, out_valid, out_chan, busy, done;
    logic out_ready = 1'b1;
    logic [4:0] fine_code;
    logic [PTS_W-1:0] out_point;
    logic [ACC_W-1:0] out_sum;

    always #5 clk = ~clk;

    ets_sweep_seq u_dut (
        .clk(clk), .rst(rst), .start(start), .cfg_wr(cfg_wr),
        .cfg_start_dly(cfg_start_dly), .cfg_points(cfg_points),
        .cfg_ovs(cfg_ovs), .cfg_period(cfg_period),
        .adc_valid(adc_valid), .adc_data(adc_data),
        .stim(stim), .strobe(strobe), .fine_code(fine_code),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_point(out_point), .out_chan(out_chan), .out_sum(out_sum),
        .busy(busy), .done(done)
    );

    // expectation state, written only by the main flow
    int e_start, e_points, e_ovs, e_period;
    bit maxmode = 1'b0;
    int chk_a = 0, fail_a = 0, chk_b = 0, fail_b = 0, wd_fail = 0;

    function automatic int sample_of(int n);
        if (maxmode) return 4095;
        return (n * 2731 + 1234) % 4096;
    endfunction

    // converter model: result two cycles after each strobe
    int ncnt = 0, nq1 = 0, nq2 = 0;
    logic s1 = 1'b0, s2 = 1'b0;
    always @(posedge clk) begin
        s1 <= strobe;
        s2 <= s1;
        nq2 <= nq1;
        if (strobe) begin
            nq1  <= ncnt;
            ncnt <= ncnt + 1;
        end
    end
    assign adc_valid = s2;
    assign adc_data  = SMP_W'(sample_of(nq2));

    function automatic longint exp_sum(int base, int p, int c, int ovs);
        longint s = 0;
        for (int k = 0; k < ovs; k++) s += sample_of(base + p * 2 * ovs + 2 * k + c);
        return s;
    endfunction

    // stall pattern on the output stream
    initial begin
        int cyc = 0;
        forever begin
            @(negedge clk);
            cyc++;
            out_ready = (cyc % 3) != 1;
        end
    end

    // monitor
    int stim_n = 0, rec_n = 0, off = 0, gap = 0, base = 0;
    logic pv = 1'b0, pr = 1'b1, pc = 1'b0;
    logic [PTS_W-1:0] pp;
    logic [ACC_W-1:0] ps;
    always @(negedge clk) begin
        if (!rst) begin
            if (start && !busy) begin
                stim_n = 0; rec_n = 0; base = ncnt; gap = 0;
            end
            gap++;
            if (stim) begin
                stim_n++;
                if (stim_n > 1 && ((stim_n - 1) % (2 * e_ovs)) != 0) begin
                    chk_a++;
                    if (gap != e_period) begin
                        fail_a++;
                        $display("FAIL R1 stimulus spacing actual %0d expected %0d", gap, e_period);
                    end
                end
                gap = 0;
                off = 0;
                chk_a++;
                if (out_valid) begin
                    fail_a++;
                    $display("FAIL R5 stimulus during record actual 1 expected 0");
                end
            end else begin
                off++;
            end
            if (strobe) begin
                int p, d;
                p = (stim_n - 1) / (2 * e_ovs);
                d = e_start + p;
                chk_a++;
                if (off != (d >> 5) || fine_code != 5'(d)) begin
                    fail_a++;
                    $display("FAIL R1/R2 strobe offset %0d fine %0d expected %0d fine %0d",
                             off, fine_code, d >> 5, d & 31);
                end
            end
            if (pv && !pr) begin
                chk_a++;
                if (!out_valid || out_chan != pc || out_point != pp || out_sum != ps) begin
                    fail_a++;
                    $display("FAIL R5 stalled record changed actual %0d/%0d/%0d expected %0d/%0d/%0d",
                             out_point, out_chan, out_sum, pp, pc, ps);
                end
            end
            if (out_valid && out_ready) begin
                int p, c;
                longint es;
                p = rec_n / 2;
                c = rec_n % 2;
                es = exp_sum(base, p, c, e_ovs);
                chk_a++;
                if (out_point != PTS_W'(p) || out_chan != c[0] || out_sum != ACC_W'(es)) begin
                    fail_a++;
                    $display("FAIL R3/R4/R5 record point %0d chan %0d sum %0d expected %0d %0d %0d",
                             out_point, out_chan, out_sum, p, c, es);
                end
                rec_n++;
            end
            pv = out_valid; pr = out_ready; pc = out_chan; pp = out_point; ps = out_sum;
        end
    end

    task automatic check_b(bit ok, string tag, int act, int exp);
        chk_b++;
        if (!ok) begin
            fail_b++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic write_cfg(int st, int pts, int ovs, int per);
        @(negedge clk);
        cfg_start_dly = DLY_W'(st); cfg_points = PTS_W'(pts);
        cfg_ovs = OVS_W'(ovs); cfg_period = PER_W'(per);
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_sweep(string tag);
        wait (done === 1'b1);
        @(negedge clk);
        check_b(rec_n == 2 * e_points, {tag, " R3/R6 record count"}, rec_n, 2 * e_points);
        check_b(stim_n == 2 * e_points * e_ovs, {tag, " R3 stimulus count"}, stim_n, 2 * e_points * e_ovs);
        check_b(!busy && done, {tag, " R6 idle with done"}, busy, 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures",
                 chk_a + chk_b + wd_fail, fail_a + fail_b + wd_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        wd_fail = 1;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8 reset state
        check_b(!stim && !strobe && !out_valid && !busy && !done, "R8 reset outputs",
                {stim, strobe, out_valid, busy, done}, 0);

        // sweep 1: fine code wraps into the coarse count
        e_start = 30; e_points = 4; e_ovs = 3; e_period = 8;
        write_cfg(30, 4, 3, 8);
        pulse_start();
        check_b(busy && !done, "R6 busy after start", busy, 1);
        repeat (20) @(negedge clk);
        write_cfg(5, 1, 1, 3);   // R7 ignored while busy
        pulse_start();           // R6 ignored while busy
        finish_sweep("sweep1");

        // rerun without a write: the ignored write must not have landed (R7)
        pulse_start();
        finish_sweep("sweep1 rerun R7");

        // sweep 2: carry from fine 31 to fine 0 with coarse 1 to 2
        e_start = 63; e_points = 2; e_ovs = 1; e_period = 6;
        write_cfg(63, 2, 1, 6);
        pulse_start();
        finish_sweep("sweep2");

        // sweep 3: every fine code visited
        e_start = 0; e_points = 40; e_ovs = 2; e_period = 4;
        write_cfg(0, 40, 2, 4);
        pulse_start();
        finish_sweep("sweep3");

        // sweep 4: full-scale results at the largest required oversampling (R4)
        maxmode = 1'b1;
        e_start = 0; e_points = 1; e_ovs = 384; e_period = 4;
        write_cfg(0, 1, 384, 4);
        pulse_start();
        finish_sweep("sweep4 R4");
        check_b(rec_n == 2, "R4 full-scale records seen", rec_n, 2);

        summary();
    end
endmodule